// File: doc/BRIEF.md
# Multi-port shared memory arbiter

This block is a small register-file memory shared by several request ports that all act in the same clock step. In each step every port asks for a read, asks for a write, or stays idle. A discipline input selects how same-step accesses to one cell are treated. The choices are strictly one access per cell, many readers but a single writer per cell, or many readers and many writers per cell.

When several writers may hit one cell, a policy input decides what is stored. Under the ranked policy the lowest port index wins. Under the agreement policy the write happens only if all writers carry the same value. Under the random policy a writer is chosen by a pseudo-random generator that restarts from a fixed seed at reset. The block returns read data and per-port error flags one cycle after the step. It also raises a per-cell flag when writers fail to agree.

Every step reads first and writes second. A read therefore always sees the cell contents from before any write in the same step. The block suits a parallel compute cluster that needs a fixed-latency shared scratch store, with access rules that can be switched between strict and permissive.

Top module: `smem_arbiter`

## Requirements
- R1: Synchronous active-high reset clears every cell to zero, drives all read data and all flags low, and loads the 8-bit generator with 0xA5.
- R2: Each port's 2-bit operation code is 0 idle, 1 read, 2 write, 3 idle. An idle port changes no cell, gets zero read data and never has its error flag set.
- R3: An unflagged read returns, one cycle after its step, the cell value held before any write of that same step. Read data is zero for any port that did not read.
- R4: With discipline code 0 (and the unused code 3), two or more active ports addressing one cell in a step all get their error bit set one cycle later. Their reads return zero and their writes are dropped. Ports at other cells are unaffected.
- R5: With discipline code 1, any number of readers may share a cell and all get its value. A cell hit by a writer together with any other access flags and suppresses every port at that cell, as in R4.
- R6: With discipline code 2, no port error is ever raised, and every read returns the pre-step value.
- R7: Under discipline 2 with policy code 0 (and the unused code 3), the writer with the lowest port index sets the cell.
- R8: Under discipline 2 with policy code 1, the cell is written only if all its writers present equal data. Otherwise the cell keeps its old value and its bit of the cell-error output is high for exactly the following cycle.
- R9: Under discipline 2 with policy code 2, let s be the generator value modulo P. The winner is the first writer found scanning port indices s, s+1, and so on, wrapping around. The generator advances every non-reset cycle, with next = {g[6:0], g[7]^g[5]^g[4]^g[3]}.
- R10: In disciplines 0 and 1, an unflagged single writer to a cell always commits, whatever the policy input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disc_i | input | 2 | Access discipline: 0 exclusive, 1 shared read, 2 shared read and write, 3 as 0 |
| pol_i | input | 2 | Write policy for discipline 2: 0 ranked, 1 agreement, 2 random, 3 as 0 |
| op_i | input | 2*P | Per-port operation code, port p at bits [2p+1:2p] |
| addr_i | input | P*AW | Per-port cell address, port p at bits [p*AW +: AW] |
| wdata_i | input | P*W | Per-port write data, port p at bits [p*W +: W] |
| rdata_o | output | P*W | Per-port read data, registered |
| port_err_o | output | P | Per-port access error, registered |
| cell_err_o | output | DEPTH | Per-cell agreement failure, registered |

## Verification
Read data and both error outputs come from the step at one clock edge and are due right after that edge. A cell update becomes visible only through a read in a later step, which appears one cycle after that later step. The bench drives each step on the falling edge. After the rising edge it runs a behavioural model that computes that step's expected outputs and then updates its own memory image and generator. At the next falling edge it compares every port's read data and both flag vectors, so every output is checked exactly in the cycle it is due.

// File: rtl/smem_pkg.sv
package smem_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        DISC_EXCL       = 2'd0,
        DISC_SHARED_RD  = 2'd1,
        DISC_SHARED_ALL = 2'd2,
        DISC_SPARE      = 2'd3
    } disc_e;

    typedef enum logic [1:0] {
        POL_RANK   = 2'd0,
        POL_AGREE  = 2'd1,
        POL_RANDOM = 2'd2,
        POL_SPARE  = 2'd3
    } pol_e;

    localparam int          GEN_W    = 8;
    localparam logic [7:0]  GEN_SEED = 8'hA5;

    function automatic logic [GEN_W-1:0] gen_step(input logic [GEN_W-1:0] g);
        return {g[6:0], g[7] ^ g[5] ^ g[4] ^ g[3]};
    endfunction

    function automatic logic is_access(input logic [1:0] op);
        return (op == OP_READ) || (op == OP_WRITE);
    endfunction

    function automatic logic is_write(input logic [1:0] op);
        return op == OP_WRITE;
    endfunction

endpackage

// File: rtl/smem_lfsr.sv
module smem_lfsr
    import smem_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [GEN_W-1:0] state_o
);
    always_ff @(posedge clk) begin
        if (rst) state_o <= GEN_SEED;
        else     state_o <= gen_step(state_o);
    end
endmodule

// File: rtl/smem_hitmap.sv
module smem_hitmap
    import smem_pkg::*;
#(
    parameter int P     = 4,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [2*P-1:0]            op_i,
    input  logic [P*AW-1:0]           addr_i,
    input  disc_e                     disc_i,
    output logic [DEPTH-1:0][P-1:0]   wr_hit_o,
    output logic [DEPTH-1:0]          cell_bad_o,
    output logic [P-1:0]              port_bad_o
);
    logic [DEPTH-1:0][P-1:0] acc_hit;

    for (genvar c = 0; c < DEPTH; c++) begin : g_cell
        always_comb begin
            acc_hit[c]  = '0;
            wr_hit_o[c] = '0;
            for (int p = 0; p < P; p++) begin
                if (int'(addr_i[p*AW +: AW]) == c) begin
                    acc_hit[c][p]  = is_access(op_i[2*p +: 2]);
                    wr_hit_o[c][p] = is_write(op_i[2*p +: 2]);
                end
            end
            unique case (disc_i)
                DISC_SHARED_ALL: cell_bad_o[c] = 1'b0;
                DISC_SHARED_RD:  cell_bad_o[c] = (wr_hit_o[c] != '0) &&
                                                 ($countones(acc_hit[c]) > 1);
                default:         cell_bad_o[c] = $countones(acc_hit[c]) > 1;
            endcase
        end
    end

    always_comb begin
        port_bad_o = '0;
        for (int p = 0; p < P; p++) begin
            for (int c = 0; c < DEPTH; c++) begin
                if (acc_hit[c][p] && cell_bad_o[c]) port_bad_o[p] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/smem_resolve.sv
module smem_resolve
    import smem_pkg::*;
#(
    parameter int P  = 4,
    parameter int W  = 8,
    parameter int PW = 2
) (
    input  logic [P-1:0]   wr_hit_i,
    input  logic [P*W-1:0] wdata_i,
    input  pol_e           pol_i,
    input  logic [PW-1:0]  start_i,
    input  logic           bad_i,
    output logic           we_o,
    output logic [W-1:0]   wval_o,
    output logic           agree_fail_o
);
    logic found;
    logic differ;

    always_comb begin
        found  = 1'b0;
        differ = 1'b0;
        wval_o = '0;
        if (pol_i == POL_RANDOM) begin
            for (int k = 0; k < P; k++) begin
                if (!found && wr_hit_i[(int'(start_i) + k) % P]) begin
                    found  = 1'b1;
                    wval_o = wdata_i[((int'(start_i) + k) % P)*W +: W];
                end
            end
        end else begin
            for (int p = 0; p < P; p++) begin
                if (!found && wr_hit_i[p]) begin
                    found  = 1'b1;
                    wval_o = wdata_i[p*W +: W];
                end
            end
        end
        if (pol_i == POL_AGREE) begin
            for (int p = 0; p < P; p++) begin
                if (wr_hit_i[p] && (wdata_i[p*W +: W] != wval_o)) differ = 1'b1;
            end
        end
        we_o         = found && !differ && !bad_i;
        agree_fail_o = found &&  differ && !bad_i;
    end
endmodule

// File: rtl/smem_arbiter.sv
module smem_arbiter
    import smem_pkg::*;
#(
    parameter int P     = 4,
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int PW   = (P > 1) ? $clog2(P) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         disc_i,
    input  logic [1:0]         pol_i,
    input  logic [2*P-1:0]     op_i,
    input  logic [P*AW-1:0]    addr_i,
    input  logic [P*W-1:0]     wdata_i,
    output logic [P*W-1:0]     rdata_o,
    output logic [P-1:0]       port_err_o,
    output logic [DEPTH-1:0]   cell_err_o
);
    disc_e                    disc;
    pol_e                     pol_eff;
    logic [GEN_W-1:0]         gen;
    logic [PW-1:0]            start;
    logic [DEPTH-1:0][P-1:0]  wr_hit;
    logic [DEPTH-1:0]         cell_bad;
    logic [P-1:0]             port_bad;
    logic [DEPTH-1:0]         we;
    logic [DEPTH-1:0][W-1:0]  wval;
    logic [DEPTH-1:0]         agree_fail;
    logic [W-1:0]             mem [DEPTH];

    assign disc    = disc_e'(disc_i);
    assign pol_eff = (disc == DISC_SHARED_ALL) ? pol_e'(pol_i) : POL_RANK;
    assign start   = PW'(int'(gen) % P);

    smem_lfsr u_gen (
        .clk     (clk),
        .rst     (rst),
        .state_o (gen)
    );

    smem_hitmap #(.P(P), .DEPTH(DEPTH)) u_hit (
        .op_i       (op_i),
        .addr_i     (addr_i),
        .disc_i     (disc),
        .wr_hit_o   (wr_hit),
        .cell_bad_o (cell_bad),
        .port_bad_o (port_bad)
    );

    for (genvar c = 0; c < DEPTH; c++) begin : g_res
        smem_resolve #(.P(P), .W(W), .PW(PW)) u_res (
            .wr_hit_i     (wr_hit[c]),
            .wdata_i      (wdata_i),
            .pol_i        (pol_eff),
            .start_i      (start),
            .bad_i        (cell_bad[c]),
            .we_o         (we[c]),
            .wval_o       (wval[c]),
            .agree_fail_o (agree_fail[c])
        );

        always_ff @(posedge clk) begin
            if (rst)        mem[c] <= '0;
            else if (we[c]) mem[c] <= wval[c];
        end

        AST_AGREE_KEEPS_CELL: assert property (@(posedge clk) disable iff (rst)
            agree_fail[c] |=> $stable(mem[c])); // R8
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o    <= '0;
            port_err_o <= '0;
            cell_err_o <= '0;
        end else begin
            for (int p = 0; p < P; p++) begin
                if ((op_i[2*p +: 2] == OP_READ) && !port_bad[p])
                    rdata_o[p*W +: W] <= mem[addr_i[p*AW +: AW]];
                else
                    rdata_o[p*W +: W] <= '0;
            end
            port_err_o <= port_bad;
            cell_err_o <= agree_fail;
        end
    end

    AST_ERR_NEVER_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $countones(port_err_o) != 1); // R4

    AST_SHARED_ALL_NO_PORT_ERR: assert property (@(posedge clk) disable iff (rst)
        (disc == DISC_SHARED_ALL) |=> (port_err_o == '0)); // R6

    for (genvar p = 0; p < P; p++) begin : g_port_chk
        AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
            !is_access(op_i[2*p +: 2]) |=> (!port_err_o[p] && rdata_o[p*W +: W] == '0)); // R2
        AST_FLAGGED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
            port_err_o[p] |-> (rdata_o[p*W +: W] == '0)); // R4
    end
endmodule

// File: tb/sim_smem_arbiter.sv
`timescale 1ns/1ps
module sim_smem_arbiter;
    localparam int P     = 4;
    localparam int DEPTH = 8;
    localparam int W     = 8;
    localparam int AW    = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       disc_i = '0;
    logic [1:0]       pol_i = '0;
    logic [2*P-1:0]   op_i = '0;
    logic [P*AW-1:0]  addr_i = '0;
    logic [P*W-1:0]   wdata_i = '0;
    logic [P*W-1:0]   rdata_o;
    logic [P-1:0]     port_err_o;
    logic [DEPTH-1:0] cell_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int           mm [DEPTH];
    logic [7:0]   ml;
    logic [W-1:0] exp_rd [P];
    logic [P-1:0] exp_pe;
    logic [DEPTH-1:0] exp_ce;

    always #2.5 clk = ~clk;

    smem_arbiter #(.P(P), .DEPTH(DEPTH), .W(W)) u0 (
        .clk(clk), .rst(rst), .disc_i(disc_i), .pol_i(pol_i), .op_i(op_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .port_err_o(port_err_o), .cell_err_o(cell_err_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic set_port(input int p, input int op, input int a, input int d);
        op_i[2*p +: 2]     = 2'(op);
        addr_i[p*AW +: AW] = AW'(a);
        wdata_i[p*W +: W]  = W'(d);
    endtask

    task automatic clear_ports();
        op_i = '0; addr_i = '0; wdata_i = '0;
    endtask

    task automatic model_eval();
        int nacc [DEPTH];
        int nwr  [DEPTH];
        bit bad  [DEPTH];
        int dsc;
        int pl;
        dsc = int'(disc_i);
        for (int c = 0; c < DEPTH; c++) begin nacc[c] = 0; nwr[c] = 0; end
        for (int p = 0; p < P; p++) begin
            int o; int a;
            o = int'(op_i[2*p +: 2]); a = int'(addr_i[p*AW +: AW]);
            if (o == 1 || o == 2) nacc[a]++;
            if (o == 2) nwr[a]++;
        end
        for (int c = 0; c < DEPTH; c++) begin
            if (dsc == 2)      bad[c] = 0;
            else if (dsc == 1) bad[c] = (nwr[c] > 0) && (nacc[c] > 1);
            else               bad[c] = nacc[c] > 1;
        end
        exp_pe = '0;
        for (int p = 0; p < P; p++) begin
            int o; int a;
            o = int'(op_i[2*p +: 2]); a = int'(addr_i[p*AW +: AW]);
            if ((o == 1 || o == 2) && bad[a]) exp_pe[p] = 1'b1;
            exp_rd[p] = (o == 1 && !exp_pe[p]) ? W'(mm[a]) : '0;
        end
        exp_ce = '0;
        pl = (dsc == 2) ? int'(pol_i) : 0;
        if (pl == 3) pl = 0;
        for (int c = 0; c < DEPTH; c++) begin
            int q[$];
            for (int p = 0; p < P; p++)
                if (int'(op_i[2*p +: 2]) == 2 && int'(addr_i[p*AW +: AW]) == c) q.push_back(p);
            if (!bad[c] && q.size() > 0) begin
                if (pl == 0) begin
                    mm[c] = int'(wdata_i[q[0]*W +: W]);
                end else if (pl == 1) begin
                    bit same;
                    same = 1;
                    foreach (q[i]) if (wdata_i[q[i]*W +: W] != wdata_i[q[0]*W +: W]) same = 0;
                    if (same) mm[c] = int'(wdata_i[q[0]*W +: W]);
                    else      exp_ce[c] = 1'b1;
                end else begin
                    int s; bit got;
                    s = int'(ml) % P; got = 0;
                    for (int k = 0; k < P; k++) begin
                        int idx;
                        idx = (s + k) % P;
                        if (!got && int'(op_i[2*idx +: 2]) == 2 && int'(addr_i[idx*AW +: AW]) == c) begin
                            got = 1; mm[c] = int'(wdata_i[idx*W +: W]);
                        end
                    end
                end
            end
        end
        ml = {ml[6:0], ml[7] ^ ml[5] ^ ml[4] ^ ml[3]};
    endtask

    task automatic compare(input string req);
        for (int p = 0; p < P; p++) chk(req, $sformatf("rdata port %0d", p), 32'(rdata_o[p*W +: W]), 32'(exp_rd[p]));
        chk(req, "port_err", 32'(port_err_o), 32'(exp_pe));
        chk(req, "cell_err", 32'(cell_err_o), 32'(exp_ce));
    endtask

    task automatic step(input string req);
        @(posedge clk);
        #1;
        model_eval();
        @(negedge clk);
        compare(req);
    endtask

    task automatic read_all(input string req);
        for (int base = 0; base < DEPTH; base += P) begin
            clear_ports();
            for (int p = 0; p < P; p++) set_port(p, 1, base + p, 0);
            disc_i = 2'd0;
            step(req);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < DEPTH; c++) mm[c] = 0;
        ml = 8'hA5;
        for (int p = 0; p < P; p++) exp_rd[p] = '0;
        exp_pe = '0; exp_ce = '0;
        compare("R1");
        read_all("R1");

        // R10: exclusive mode, distinct cells, single writers commit under any policy
        clear_ports(); disc_i = 2'd0; pol_i = 2'd1;
        set_port(0, 2, 1, 8'h11); set_port(1, 2, 2, 8'h22); set_port(2, 2, 3, 8'h33);
        step("R10");
        clear_ports(); disc_i = 2'd1; pol_i = 2'd2;
        set_port(3, 2, 7, 8'h77);
        step("R10");
        read_all("R10");

        // R2: idle and code 3 ports
        clear_ports(); set_port(0, 3, 1, 8'hEE); set_port(1, 0, 1, 8'hEE); set_port(2, 1, 1, 0);
        step("R2");

        // R3: read sees pre-step value
        clear_ports(); disc_i = 2'd2; pol_i = 2'd0;
        set_port(0, 2, 1, 8'h55); set_port(1, 1, 1, 0);
        step("R3");
        clear_ports(); set_port(2, 1, 1, 0);
        step("R3");

        // R4: exclusive conflicts, including spare discipline code
        clear_ports(); disc_i = 2'd0;
        set_port(0, 1, 2, 0); set_port(1, 1, 2, 0); set_port(2, 2, 4, 8'h44);
        step("R4");
        clear_ports(); set_port(0, 2, 3, 8'h99); set_port(1, 1, 3, 0); set_port(3, 1, 4, 0);
        step("R4");
        clear_ports(); disc_i = 2'd3; set_port(2, 1, 5, 0); set_port(3, 2, 5, 8'h12);
        step("R4");

        // R5: shared reads, write mixed with access flagged
        clear_ports(); disc_i = 2'd1;
        set_port(0, 1, 3, 0); set_port(1, 1, 3, 0); set_port(2, 1, 3, 0);
        step("R5");
        clear_ports(); set_port(0, 2, 3, 8'hAB); set_port(1, 1, 3, 0); set_port(2, 1, 4, 0);
        step("R5");
        clear_ports(); set_port(0, 2, 6, 8'h01); set_port(1, 2, 6, 8'h02);
        step("R5");
        read_all("R5");

        // R7: ranked policy
        clear_ports(); disc_i = 2'd2; pol_i = 2'd0;
        set_port(1, 2, 5, 8'hA1); set_port(2, 2, 5, 8'hA2); set_port(3, 2, 5, 8'hA3);
        step("R7");
        clear_ports(); pol_i = 2'd3; set_port(2, 2, 6, 8'hB2); set_port(3, 2, 6, 8'hB3);
        step("R7");
        read_all("R7");

        // R8: agreement policy
        clear_ports(); disc_i = 2'd2; pol_i = 2'd1;
        set_port(0, 2, 0, 8'h3C); set_port(2, 2, 0, 8'h3C);
        step("R8");
        clear_ports(); set_port(1, 2, 0, 8'h01); set_port(3, 2, 0, 8'h02); set_port(0, 1, 0, 0);
        step("R8");
        clear_ports(); set_port(0, 1, 0, 0);
        step("R8");

        // R9: random policy, all ports contend
        for (int i = 0; i < 12; i++) begin
            clear_ports(); disc_i = 2'd2; pol_i = 2'd2;
            for (int p = 0; p < P; p++) set_port(p, 2, 6, 8'h60 + p);
            set_port(0, 2, 6, 8'h60 + 16 * i);
            step("R9");
            clear_ports(); set_port(1, 1, 6, 0);
            step("R9");
        end

        // R6 and mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            string tag;
            clear_ports();
            disc_i = 2'($urandom % 4);
            pol_i  = 2'($urandom % 4);
            for (int p = 0; p < P; p++)
                set_port(p, int'($urandom % 4), int'($urandom % ((i % 2) ? 4 : DEPTH)), int'($urandom % 3));
            if (disc_i == 2'd1)      tag = "R5";
            else if (disc_i != 2'd2) tag = "R4";
            else if (pol_i == 2'd1)  tag = "R8";
            else if (pol_i == 2'd2)  tag = "R9";
            else if (i % 3 == 0)     tag = "R6";
            else                     tag = "R7";
            step(tag);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule